// File: doc/BRIEF.md
# Debug Event Dispatch Controller

This block sits beside a processor pipeline and decides, once per cycle, what the core must do when debug events arrive while it is not in debug state. Software events come flagged against the instruction being presented: breakpoint, breakpoint instruction, address or context-ID match, the two vector catches (prefetch side and data side) and watchpoint. Halting requests come from a level-sensitive external pin or from a one-cycle write strobe of a halt control bit. The write is remembered until the request can be served.

A debug enable input and a two-bit mode select set the routing. The routing maps each event to one of four outcomes: ignore it, enter debug state, raise a prefetch abort debug exception or raise a data abort debug exception. An exception also loads a link value, which is the faulting instruction address plus an offset. Only one outcome is taken per cycle, chosen by a fixed priority. An acknowledge marks debug entry and holds the block idle until the core leaves debug state. All outputs are registered, so each outcome appears one clock after the inputs that caused it.

Top module: `dbg_event_dispatch`

## Requirements
- R1: While `rstN` is low every output is 0, `linkVal` included, and no halt request is pending.
- R2: With `dbgEn` low, whatever `modeSel` holds, a breakpoint instruction (`evBkpt`) raises `pabtExc` and loads `linkVal` with `instrAddr`+4. Every other software event and both halting sources give no outcome.
- R3: With `dbgEn` high and `modeSel`=2'b00, software events behave as in R2. A halting request (`extHaltReq` or a pending control-bit halt) raises `enterDebug`.
- R4: With `dbgEn` high and `modeSel[0]`=1, every software event and every halting request raises `enterDebug`, and no exception is raised.
- R5: With `dbgEn` high and `modeSel`=2'b10, breakpoint, breakpoint instruction and match raise `pabtExc` with `linkVal`=`instrAddr`+4. A watchpoint raises `dabtExc` with `linkVal`=`instrAddr`+8. Both vector catches are ignored, and halting requests raise `enterDebug`.
- R6: When several non-ignored events coincide, one outcome is taken, by the order halt, breakpoint, breakpoint instruction, match, prefetch vector catch, data vector catch, watchpoint. At most one of `enterDebug`, `pabtExc` and `dabtExc` is high in any cycle.
- R7: `cancelInstr` is high with any taken outcome while `instrValid` was high. A watchpoint is not taken when a non-ignored cancelling event (breakpoint, breakpoint instruction, match, vector catch) or a halt is taken on the same instruction.
- R8: A watchpoint that comes with `preciseDabt` high is never taken.
- R9: A one-cycle `haltWrite` stays pending until it can be served, for example while debug is disabled, and then raises `enterDebug`. Serving it clears it.
- R10: `dbgAck` rises together with `enterDebug` and stays high until the cycle after `inDebug` falls. While `dbgAck` or `inDebug` is high, no outcome is taken, and a halt request that is already pending stays pending.
- R11: Outcomes, `cancelInstr` and `linkVal` appear on the clock edge after the inputs that produced them. `linkVal` holds its value until the next exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgEn | input | 1 | Debug enable; low disables debug |
| modeSel | input | 2 | Debug mode select (00 none, x1 halting, 10 monitor) |
| instrValid | input | 1 | Software event flags refer to a valid instruction |
| evBrk | input | 1 | Breakpoint hit |
| evBkpt | input | 1 | Breakpoint instruction executed |
| evMatch | input | 1 | Address or context-ID match |
| evVcPabt | input | 1 | Prefetch-abort vector catch |
| evVcDabt | input | 1 | Data-abort vector catch |
| evWpt | input | 1 | Watchpoint hit |
| preciseDabt | input | 1 | Precise data abort on the same access |
| instrAddr | input | ADDR_W | Address of the instruction |
| extHaltReq | input | 1 | External halt request level |
| haltWrite | input | 1 | Write strobe of the halt control bit |
| inDebug | input | 1 | Core is in debug state |
| enterDebug | output | 1 | Debug state entry pulse |
| dbgAck | output | 1 | Debug entry acknowledge |
| pabtExc | output | 1 | Prefetch abort debug exception pulse |
| dabtExc | output | 1 | Data abort debug exception pulse |
| cancelInstr | output | 1 | Instruction is cancelled |
| linkVal | output | ADDR_W | Abort link value |

## Verification
The bench builds the block with its default parameters: a 32-bit address and link offsets of 4 and 8. With these values the link results can be compared against the plain address arithmetic. Random addresses reach the upper address bits, so any carry into them is exercised. Because the offsets differ, a prefetch exception and a data exception load different link values, and the bench can tell which offset was applied.

// File: rtl/dbg_disp_pkg.sv
package dbg_disp_pkg;

  typedef enum logic [1:0] {MODE_OFF, MODE_NONE, MODE_HALT, MODE_MON} effMode_e;
  typedef enum logic [1:0] {ACT_IGN, ACT_DBG, ACT_PABT, ACT_DABT} act_e;

  // Event slots; the index is the priority, lowest index wins.
  localparam int EV_N    = 7;
  localparam int EV_HALT = 0;
  localparam int EV_BRK  = 1;
  localparam int EV_BKPT = 2;
  localparam int EV_MTCH = 3;
  localparam int EV_VCP  = 4;
  localparam int EV_VCD  = 5;
  localparam int EV_WPT  = 6;

  typedef struct packed {
    logic enter;
    logic pabt;
    logic dabt;
    logic cancel;
  } strobe_t;

  function automatic effMode_e decodeMode(input logic en, input logic [1:0] sel);
    if (!en)              return MODE_OFF;
    else if (sel[0])      return MODE_HALT;
    else if (sel == 2'b10) return MODE_MON;
    else                  return MODE_NONE;
  endfunction

  function automatic act_e routeEvent(input effMode_e m, input int idx);
    if (idx == EV_HALT) return (m == MODE_OFF) ? ACT_IGN : ACT_DBG;
    case (m)
      MODE_HALT: return ACT_DBG;
      MODE_MON: begin
        if (idx == EV_VCP || idx == EV_VCD) return ACT_IGN;
        if (idx == EV_WPT) return ACT_DABT;
        return ACT_PABT;
      end
      default: return (idx == EV_BKPT) ? ACT_PABT : ACT_IGN;
    endcase
  endfunction

endpackage

// File: rtl/dbg_disp_prio.sv
module dbg_disp_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         anyGnt
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]       = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign anyGnt = blocked[N];
endmodule

// File: rtl/dbg_disp_ctrl.sv
module dbg_disp_ctrl
  import dbg_disp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dbgEn,
  input  logic [1:0] modeSel,
  input  logic       instrValid,
  input  logic       evBrk,
  input  logic       evBkpt,
  input  logic       evMatch,
  input  logic       evVcPabt,
  input  logic       evVcDabt,
  input  logic       evWpt,
  input  logic       preciseDabt,
  input  logic       extHaltReq,
  input  logic       haltWrite,
  input  logic       inDebug,
  output strobe_t    str,
  output logic       ackQ
);
  effMode_e       mode;
  logic           stickyQ;
  logic           inDebugQ;
  logic           eligible;
  logic [EV_N-1:0] raw;
  logic [EV_N-1:0] req;
  logic [EV_N-1:0] gnt;
  logic           anyGnt;
  act_e           actV [EV_N];
  act_e           selAct;

  assign mode     = decodeMode(dbgEn, modeSel);
  assign eligible = !inDebug && !ackQ;

  assign raw[EV_HALT] = extHaltReq | stickyQ;
  assign raw[EV_BRK]  = instrValid & evBrk;
  assign raw[EV_BKPT] = instrValid & evBkpt;
  assign raw[EV_MTCH] = instrValid & evMatch;
  assign raw[EV_VCP]  = instrValid & evVcPabt;
  assign raw[EV_VCD]  = instrValid & evVcDabt;
  assign raw[EV_WPT]  = instrValid & evWpt & ~preciseDabt;

  for (genvar i = 0; i < EV_N; i++) begin : g_route
    assign actV[i] = routeEvent(mode, i);
    assign req[i]  = eligible & raw[i] & (actV[i] != ACT_IGN);
  end

  dbg_disp_prio #(.N(EV_N)) u_prio (
    .req    (req),
    .gnt    (gnt),
    .anyGnt (anyGnt)
  );

  always_comb begin
    selAct = ACT_IGN;
    for (int i = 0; i < EV_N; i++) begin
      if (gnt[i]) selAct = actV[i];
    end
  end

  always_comb begin
    str.enter  = anyGnt && (selAct == ACT_DBG);
    str.pabt   = anyGnt && (selAct == ACT_PABT);
    str.dabt   = anyGnt && (selAct == ACT_DABT);
    str.cancel = anyGnt && instrValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ  <= 1'b0;
      ackQ     <= 1'b0;
      inDebugQ <= 1'b0;
    end else begin
      inDebugQ <= inDebug;
      if (gnt[EV_HALT])     stickyQ <= 1'b0;
      else if (haltWrite)   stickyQ <= 1'b1;
      if (str.enter)                 ackQ <= 1'b1;
      else if (inDebugQ && !inDebug) ackQ <= 1'b0;
    end
  end

  // R2
  no_entry_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEn |-> !str.enter);

  // R8
  no_wpt_on_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    preciseDabt |-> !str.dabt);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stickyQ && !str.enter) |=> stickyQ);

  // R10
  no_dispatch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ || inDebug) |-> !(str.enter || str.pabt || str.dabt));

  // R10
  ack_follows_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.enter |=> ackQ);
endmodule

// File: rtl/dbg_disp_dpath.sv
module dbg_disp_dpath
  import dbg_disp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PABT_OFS = 4,
  parameter int WPT_OFS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic              enterDebug,
  output logic              pabtExc,
  output logic              dabtExc,
  output logic              cancelInstr,
  output logic [ADDR_W-1:0] linkVal
);
  localparam logic [ADDR_W-1:0] P_OFS = ADDR_W'(PABT_OFS);
  localparam logic [ADDR_W-1:0] D_OFS = ADDR_W'(WPT_OFS);

  logic [ADDR_W-1:0] linkNext;

  assign linkNext = instrAddr + (str.dabt ? D_OFS : P_OFS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enterDebug  <= 1'b0;
      pabtExc     <= 1'b0;
      dabtExc     <= 1'b0;
      cancelInstr <= 1'b0;
      linkVal     <= '0;
    end else begin
      enterDebug  <= str.enter;
      pabtExc     <= str.pabt;
      dabtExc     <= str.dabt;
      cancelInstr <= str.cancel;
      if (str.pabt || str.dabt) linkVal <= linkNext;
    end
  end

  // R6
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enterDebug, pabtExc, dabtExc}));

  // R5
  wpt_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    dabtExc |-> (linkVal == $past(instrAddr) + D_OFS));

  // R11
  link_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.pabt || str.dabt) |=> $stable(linkVal));
endmodule

// File: rtl/dbg_event_dispatch.sv
module dbg_event_dispatch
  import dbg_disp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PABT_OFS = 4,
  parameter int WPT_OFS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgEn,
  input  logic [1:0]        modeSel,
  input  logic              instrValid,
  input  logic              evBrk,
  input  logic              evBkpt,
  input  logic              evMatch,
  input  logic              evVcPabt,
  input  logic              evVcDabt,
  input  logic              evWpt,
  input  logic              preciseDabt,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic              extHaltReq,
  input  logic              haltWrite,
  input  logic              inDebug,
  output logic              enterDebug,
  output logic              dbgAck,
  output logic              pabtExc,
  output logic              dabtExc,
  output logic              cancelInstr,
  output logic [ADDR_W-1:0] linkVal
);
  strobe_t str;

  dbg_disp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .dbgEn       (dbgEn),
    .modeSel     (modeSel),
    .instrValid  (instrValid),
    .evBrk       (evBrk),
    .evBkpt      (evBkpt),
    .evMatch     (evMatch),
    .evVcPabt    (evVcPabt),
    .evVcDabt    (evVcDabt),
    .evWpt       (evWpt),
    .preciseDabt (preciseDabt),
    .extHaltReq  (extHaltReq),
    .haltWrite   (haltWrite),
    .inDebug     (inDebug),
    .str         (str),
    .ackQ        (dbgAck)
  );

  dbg_disp_dpath #(
    .ADDR_W   (ADDR_W),
    .PABT_OFS (PABT_OFS),
    .WPT_OFS  (WPT_OFS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .instrAddr   (instrAddr),
    .enterDebug  (enterDebug),
    .pabtExc     (pabtExc),
    .dabtExc     (dabtExc),
    .cancelInstr (cancelInstr),
    .linkVal     (linkVal)
  );
endmodule

// File: tb/sim_dbg_event_dispatch.sv
module sim_dbg_event_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int N_RANDOM = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dbgEn = 0, instrValid = 0, evBrk = 0, evBkpt = 0, evMatch = 0;
  logic evVcPabt = 0, evVcDabt = 0, evWpt = 0, preciseDabt = 0;
  logic extHaltReq = 0, haltWrite = 0, inDebug = 0;
  logic [1:0] modeSel = 2'b00;
  logic [AW-1:0] instrAddr = '0;
  logic enterDebug, dbgAck, pabtExc, dabtExc, cancelInstr;
  logic [AW-1:0] linkVal;

  int checks = 0;
  int failures = 0;
  int debCnt = 0;

  // bench model state
  logic mSticky = 0, mAck = 0, mInDbgQ = 0;
  logic [AW-1:0] mLink = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_event_dispatch u0 (
    .clk(clk), .rstN(rstN), .dbgEn(dbgEn), .modeSel(modeSel),
    .instrValid(instrValid), .evBrk(evBrk), .evBkpt(evBkpt),
    .evMatch(evMatch), .evVcPabt(evVcPabt), .evVcDabt(evVcDabt),
    .evWpt(evWpt), .preciseDabt(preciseDabt), .instrAddr(instrAddr),
    .extHaltReq(extHaltReq), .haltWrite(haltWrite), .inDebug(inDebug),
    .enterDebug(enterDebug), .dbgAck(dbgAck), .pabtExc(pabtExc),
    .dabtExc(dabtExc), .cancelInstr(cancelInstr), .linkVal(linkVal)
  );

  // 0 ignore, 1 debug entry, 2 prefetch abort, 3 data abort
  // ev: 1 brk, 2 bkpt, 3 match, 4 vc pabt, 5 vc dabt, 6 watchpoint
  function automatic int evAction(input logic en, input logic [1:0] m, input int ev);
    if (!en || m == 2'b00) return (ev == 2) ? 2 : 0;
    if (m[0]) return 1;
    if (ev == 4 || ev == 5) return 0;
    if (ev == 6) return 3;
    return 2;
  endfunction

  function automatic string modeTag(input logic en, input logic [1:0] m);
    if (!en) return "R2";
    if (m == 2'b00) return "R3";
    if (m[0]) return "R4";
    return "R5";
  endfunction

  task automatic clearIns();
    instrValid = 0; evBrk = 0; evBkpt = 0; evMatch = 0; evVcPabt = 0;
    evVcDabt = 0; evWpt = 0; preciseDabt = 0; extHaltReq = 0; haltWrite = 0;
  endtask

  // Compute the expected outcome of the inputs now applied, let one edge pass,
  // and compare at the following falling edge.
  task automatic tick(input string tagIn);
    int act;
    int nAct;
    logic haltTaken;
    logic [4:0] expV, gotV;
    string tag;
    logic [4:0] evs;
    act = 0; nAct = 0; haltTaken = 0;
    tag = modeTag(dbgEn, modeSel);
    evs = {evVcDabt, evVcPabt, evMatch, evBkpt, evBrk};
    if (inDebug || mAck) begin
      tag = "R10";
    end else if ((extHaltReq || mSticky) && dbgEn) begin
      act = 1; haltTaken = 1;
      if (!extHaltReq) tag = "R9";
    end else if (instrValid) begin
      for (int e = 1; e <= 5; e++) begin
        if (evs[e-1] && evAction(dbgEn, modeSel, e) != 0) begin
          nAct++;
          if (act == 0) act = evAction(dbgEn, modeSel, e);
        end
      end
      if (nAct > 1) tag = "R6";
      if (evWpt) begin
        if (act != 0) tag = "R7";
        else if (preciseDabt) tag = "R8";
        else act = evAction(dbgEn, modeSel, 6);
      end
    end
    if (act == 2) mLink = instrAddr + 32'd4;
    if (act == 3) mLink = instrAddr + 32'd8;
    if (haltTaken) mSticky = 0;
    else if (haltWrite) mSticky = 1;
    if (act == 1) mAck = 1;
    else if (mInDbgQ && !inDebug) mAck = 0;
    mInDbgQ = inDebug;
    if (tagIn != "") tag = tagIn;
    expV = {act == 1, act == 2, act == 3, (act != 0) && instrValid, mAck};
    @(negedge clk);
    gotV = {enterDebug, pabtExc, dabtExc, cancelInstr, dbgAck};
    checks++;
    if (gotV !== expV || linkVal !== mLink) begin
      failures++;
      $display("FAIL %s: {enter,pabt,dabt,cancel,ack}=%b link=%h expected %b link=%h",
               tag, gotV, linkVal, expV, mLink);
    end
  endtask

  task automatic leaveDebug();
    clearIns();
    inDebug = 1;
    tick("R10");
    tick("R10");
    inDebug = 0;
    tick("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d0c5eed));
    repeat (3) @(negedge clk);
    checks++;
    if ({enterDebug, dbgAck, pabtExc, dabtExc, cancelInstr} !== 5'b0 || linkVal !== '0) begin
      failures++;
      $display("FAIL R1: outputs=%b link=%h expected 00000 link=0",
               {enterDebug, dbgAck, pabtExc, dabtExc, cancelInstr}, linkVal);
    end
    rstN = 1;

    // R2: BKPT with debug disabled gives a prefetch abort, link +4
    dbgEn = 0; modeSel = 2'b01; instrValid = 1; evBkpt = 1; instrAddr = 32'h0000_0100;
    tick("R2");
    clearIns();
    // R2: other events and halts ignored while disabled
    instrValid = 1; evBrk = 1; evWpt = 1; extHaltReq = 1;
    tick("R2");
    clearIns();
    // R9: halt write while disabled stays pending
    haltWrite = 1;
    tick("R9");
    clearIns();
    tick("R9");
    tick("R9");
    // R9/R3: enabling debug serves the pending halt
    dbgEn = 1; modeSel = 2'b00;
    tick("R9");
    tick("R10");
    leaveDebug();
    // R5: monitor mode, vector catches ignored
    modeSel = 2'b10; instrValid = 1; evVcPabt = 1; evVcDabt = 1;
    tick("R5");
    clearIns();
    // R5: watchpoint raises data abort, link +8
    instrValid = 1; evWpt = 1; instrAddr = 32'hFFFF_FFFC;
    tick("R5");
    clearIns();
    // R8: precise data abort masks the watchpoint
    instrValid = 1; evWpt = 1; preciseDabt = 1; instrAddr = 32'h0000_2000;
    tick("R8");
    clearIns();
    // R7: match cancels instruction, watchpoint not taken
    instrValid = 1; evMatch = 1; evWpt = 1; instrAddr = 32'h0000_3000;
    tick("R7");
    clearIns();
    // R6: halt beats breakpoint in monitor mode
    extHaltReq = 1; instrValid = 1; evBrk = 1;
    tick("R6");
    clearIns();
    leaveDebug();
    // R4: halting mode, breakpoint with watchpoint enters debug
    modeSel = 2'b11; instrValid = 1; evBrk = 1; evWpt = 1;
    tick("R4");
    clearIns();
    leaveDebug();

    for (int n = 0; n < N_RANDOM; n++) begin
      dbgEn       = ($urandom % 4) != 0;
      modeSel     = 2'($urandom % 4);
      instrValid  = ($urandom % 10) < 7;
      evBrk       = ($urandom % 6) == 0;
      evBkpt      = ($urandom % 6) == 0;
      evMatch     = ($urandom % 6) == 0;
      evVcPabt    = ($urandom % 6) == 0;
      evVcDabt    = ($urandom % 6) == 0;
      evWpt       = ($urandom % 4) == 0;
      preciseDabt = ($urandom % 5) == 0;
      extHaltReq  = ($urandom % 12) == 0;
      haltWrite   = ($urandom % 12) == 0;
      instrAddr   = $urandom;
      if (debCnt > 0) begin
        inDebug = 1; debCnt--;
      end else if (inDebug) begin
        inDebug = 0;
      end else if (dbgAck) begin
        debCnt = 2; inDebug = 1;
      end
      tick("");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule